// File: doc/BRIEF.md
# Bidirectional Bus Address Translation Unit

This block remaps addresses that cross between a local processor bus and a PCI-style memory space. Each direction has a memory window, which is the region of the source address space that is claimed, and a translation window, which is the region of the destination space that receives the traffic. An address that falls inside the memory window keeps its offset within the window. The part of the address above the window size is replaced by the translation base. The outbound lane handles processor addresses headed for PCI space. The inbound lane handles PCI memory addresses headed for local memory.

Software programs four registers through a plain register port. There are two base registers and two translation registers, and each translation register also carries a 5-bit size code. A size code of zero turns its lane off. Each lane takes lookups over a valid/ready stream and returns the result over a valid/ready stream. The result is a hit flag and the outgoing address, produced one cycle after the lookup is accepted. A result that the consumer has not taken stays on the output unchanged. A new lookup is accepted only when the output register is empty or is being drained in that same cycle. Overlapping windows are not supported, and the unit gives no defined result for them.

Top module: `addr_xlate_unit`

## Requirements
- R1: An outbound lookup whose address matches the outbound base in every bit at or above the window size returns hit=1 and an address made of the outbound translation base (bits above the window size) joined to the lookup address (bits below it).
- R2: The inbound lane behaves as in R1, using the inbound base register and the inbound translation register.
- R3: When a lane's size code (translation register bits 4:0) is zero, every lookup on that lane returns hit=0.
- R4: A nonzero size code n gives a window of 2^(n+1) bytes. Codes from 1 to 10 are treated as 11 (4 KiB), and code 31 is treated as 30 (2 GiB).
- R5: The registers sit at these offsets: outbound base at 0x300 or 0x2300, outbound translation at 0x308 or 0x2308, inbound translation at 0x310 or 0x2310, and inbound base at 0x010. Base registers hold bits 31:12. Translation registers hold bits 31:12 and the size code in bits 4:0. All other bits read as zero. Read data is combinational from the register address.
- R6: A read from any other offset returns zero, and a write to any other offset changes no register.
- R7: After reset every register reads zero, so both lanes start disabled, and neither output is valid.
- R8: A result appears on the clock edge that accepts its lookup. A register write takes effect at the following edge, so a lookup accepted together with a write still uses the old register values.
- R9: in_ready is high exactly when the output is empty or out_ready is high. While out_valid is high and out_ready is low, the output and the hit flag hold steady.
- R10: A lookup that misses returns hit=0 and passes its address through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| ob_in_valid | input | 1 | Outbound lookup valid |
| ob_in_ready | output | 1 | Outbound lookup accepted |
| ob_in_addr | input | 32 | Processor-side address |
| ob_out_valid | output | 1 | Outbound result valid |
| ob_out_ready | input | 1 | Outbound result taken |
| ob_out_hit | output | 1 | Outbound window hit |
| ob_out_addr | output | 32 | PCI-side address |
| ib_in_valid | input | 1 | Inbound lookup valid |
| ib_in_ready | output | 1 | Inbound lookup accepted |
| ib_in_addr | input | 32 | PCI-side address |
| ib_out_valid | output | 1 | Inbound result valid |
| ib_out_ready | input | 1 | Inbound result taken |
| ib_out_hit | output | 1 | Inbound window hit |
| ib_out_addr | output | 32 | Local-memory address |

## Verification
Register read data is due in the same cycle as the offset, so the bench checks it a short delay after driving the inputs. A lookup result is due on the edge that accepts the lookup, and a register write first affects lookups accepted on the edge after it. The reference model in the bench updates its own state once per edge with the same ordering: lookups use the old registers, then the write is applied. At each falling edge the model's state is compared with the outputs. A stalled result must then still match the value the model is holding, which also covers R9 under random out_ready.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OB_BASE,
    SEL_OB_XLAT,
    SEL_IB_BASE,
    SEL_IB_XLAT
  } reg_sel_e;

  localparam logic [15:0] OFS_OB_BASE   = 16'h0300;
  localparam logic [15:0] OFS_OB_XLAT   = 16'h0308;
  localparam logic [15:0] OFS_IB_XLAT   = 16'h0310;
  localparam logic [15:0] OFS_LOCAL_ADD = 16'h2000;
  localparam logic [15:0] OFS_IB_BASE   = 16'h0010;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs #(
  parameter int AW     = 32,
  parameter int RAW    = 16,
  parameter int SW     = 5,
  parameter int PG_LSB = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] addr,
  input  logic [AW-1:0]  wdata,
  output logic [AW-1:0]  rdata,
  output logic [AW-1:0]  ob_base,
  output logic [AW-1:0]  ob_xbase,
  output logic [SW-1:0]  ob_size,
  output logic [AW-1:0]  ib_base,
  output logic [AW-1:0]  ib_xbase,
  output logic [SW-1:0]  ib_size
);
  import xlate_pkg::*;

  localparam int HW = AW - PG_LSB;

  reg_sel_e         sel;
  logic [HW-1:0]    ob_base_q, ob_xl_q, ib_base_q, ib_xl_q;
  logic [SW-1:0]    ob_size_q, ib_size_q;

  always_comb begin
    sel = SEL_NONE;
    if (RAW'(addr) == RAW'(OFS_OB_BASE) || RAW'(addr) == RAW'(OFS_OB_BASE | OFS_LOCAL_ADD))
      sel = SEL_OB_BASE;
    else if (RAW'(addr) == RAW'(OFS_OB_XLAT) || RAW'(addr) == RAW'(OFS_OB_XLAT | OFS_LOCAL_ADD))
      sel = SEL_OB_XLAT;
    else if (RAW'(addr) == RAW'(OFS_IB_XLAT) || RAW'(addr) == RAW'(OFS_IB_XLAT | OFS_LOCAL_ADD))
      sel = SEL_IB_XLAT;
    else if (RAW'(addr) == RAW'(OFS_IB_BASE))
      sel = SEL_IB_BASE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_base_q <= '0;
      ob_xl_q   <= '0;
      ob_size_q <= '0;
      ib_base_q <= '0;
      ib_xl_q   <= '0;
      ib_size_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OB_BASE: ob_base_q <= wdata[AW-1:PG_LSB];
        SEL_OB_XLAT: begin
          ob_xl_q   <= wdata[AW-1:PG_LSB];
          ob_size_q <= wdata[SW-1:0];
        end
        SEL_IB_BASE: ib_base_q <= wdata[AW-1:PG_LSB];
        SEL_IB_XLAT: begin
          ib_xl_q   <= wdata[AW-1:PG_LSB];
          ib_size_q <= wdata[SW-1:0];
        end
        default: ;
      endcase
    end
  end

  assign ob_base  = {ob_base_q, {PG_LSB{1'b0}}};
  assign ob_xbase = {ob_xl_q, {PG_LSB{1'b0}}};
  assign ib_base  = {ib_base_q, {PG_LSB{1'b0}}};
  assign ib_xbase = {ib_xl_q, {PG_LSB{1'b0}}};
  assign ob_size  = ob_size_q;
  assign ib_size  = ib_size_q;

  always_comb begin
    case (sel)
      SEL_OB_BASE: rdata = ob_base;
      SEL_OB_XLAT: rdata = ob_xbase | AW'(ob_size_q);
      SEL_IB_BASE: rdata = ib_base;
      SEL_IB_XLAT: rdata = ib_xbase | AW'(ib_size_q);
      default:     rdata = '0;
    endcase
  end

  logic [4*HW+2*SW-1:0] all_q;
  assign all_q = {ob_base_q, ob_xl_q, ob_size_q, ib_base_q, ib_xl_q, ib_size_q};

  // R6: writes to unmapped offsets leave every register alone
  a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> $stable(all_q));

  // R8: register contents change only through a write strobe
  a_r8_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(all_q));
endmodule

// File: rtl/xlate_lane.sv
module xlate_lane #(
  parameter int AW    = 32,
  parameter int SW    = 5,
  parameter int MIN_N = 11,
  parameter int MAX_N = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [AW-1:0] win_base,
  input  logic [AW-1:0] xl_base,
  input  logic [SW-1:0] size_code,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_hit,
  output logic [AW-1:0] out_addr
);
  function automatic logic [AW-1:0] low_mask(input logic [SW-1:0] code);
    int n;
    logic [63:0] span;
    n = int'(code);
    if (n < MIN_N) n = MIN_N;
    if (n > MAX_N) n = MAX_N;
    span = (64'd1 << (n + 1)) - 64'd1;
    return span[AW-1:0];
  endfunction

  logic          lane_on;
  logic [AW-1:0] mask;
  logic          hit_c;
  logic [AW-1:0] addr_c;

  always_comb begin
    lane_on = (size_code != '0);
    mask    = low_mask(size_code);
    hit_c   = lane_on && (((in_addr ^ win_base) & ~mask) == '0);
    addr_c  = hit_c ? ((xl_base & ~mask) | (in_addr & mask)) : in_addr;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit  <= hit_c;
        out_addr <= addr_c;
      end
    end
  end

  // R9: a stalled result stays put
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_hit)));

  // R3: a disabled lane never reports a hit
  a_r3_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && size_code == '0) |=> !out_hit);

  // R1/R10: the page offset always passes straight through
  a_r10_page_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_addr[11:0] == $past(in_addr[11:0])));
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit #(
  parameter int AW     = 32,
  parameter int RAW    = 16,
  parameter int SW     = 5,
  parameter int PG_LSB = 12,
  parameter int MIN_N  = 11,
  parameter int MAX_N  = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic           ob_in_valid,
  output logic           ob_in_ready,
  input  logic [AW-1:0]  ob_in_addr,
  output logic           ob_out_valid,
  input  logic           ob_out_ready,
  output logic           ob_out_hit,
  output logic [AW-1:0]  ob_out_addr,
  input  logic           ib_in_valid,
  output logic           ib_in_ready,
  input  logic [AW-1:0]  ib_in_addr,
  output logic           ib_out_valid,
  input  logic           ib_out_ready,
  output logic           ib_out_hit,
  output logic [AW-1:0]  ib_out_addr
);
  logic [AW-1:0] ob_base, ob_xbase, ib_base, ib_xbase;
  logic [SW-1:0] ob_size, ib_size;

  xlate_regs #(.AW(AW), .RAW(RAW), .SW(SW), .PG_LSB(PG_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ob_base(ob_base), .ob_xbase(ob_xbase), .ob_size(ob_size),
    .ib_base(ib_base), .ib_xbase(ib_xbase), .ib_size(ib_size)
  );

  xlate_lane #(.AW(AW), .SW(SW), .MIN_N(MIN_N), .MAX_N(MAX_N)) u_ob (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ob_in_valid), .in_ready(ob_in_ready), .in_addr(ob_in_addr),
    .win_base(ob_base), .xl_base(ob_xbase), .size_code(ob_size),
    .out_valid(ob_out_valid), .out_ready(ob_out_ready),
    .out_hit(ob_out_hit), .out_addr(ob_out_addr)
  );

  xlate_lane #(.AW(AW), .SW(SW), .MIN_N(MIN_N), .MAX_N(MAX_N)) u_ib (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ib_in_valid), .in_ready(ib_in_ready), .in_addr(ib_in_addr),
    .win_base(ib_base), .xl_base(ib_xbase), .size_code(ib_size),
    .out_valid(ib_out_valid), .out_ready(ib_out_ready),
    .out_hit(ib_out_hit), .out_addr(ib_out_addr)
  );

  // R7: nothing is valid in the first cycle out of reset
  a_r7_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ob_out_valid && !ib_out_valid));
endmodule

// File: tb/addr_xlate_unit_test.sv
module addr_xlate_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr = 1'b0;
  logic [15:0] ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        ob_iv = 1'b0, ob_or = 1'b1, ib_iv = 1'b0, ib_or = 1'b1;
  logic [31:0] ob_ia = '0, ib_ia = '0;
  logic        ob_ir, ob_ov, ob_hit, ib_ir, ib_ov, ib_hit;
  logic [31:0] ob_oa, ib_oa;

  addr_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(ra), .reg_wdata(wd), .reg_rdata(rd),
    .ob_in_valid(ob_iv), .ob_in_ready(ob_ir), .ob_in_addr(ob_ia),
    .ob_out_valid(ob_ov), .ob_out_ready(ob_or), .ob_out_hit(ob_hit), .ob_out_addr(ob_oa),
    .ib_in_valid(ib_iv), .ib_in_ready(ib_ir), .ib_in_addr(ib_ia),
    .ib_out_valid(ib_ov), .ib_out_ready(ib_or), .ib_out_hit(ib_hit), .ib_out_addr(ib_oa)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_obb = 0, m_obt = 0, m_ibb = 0, m_ibt = 0;
  logic        m_ov = 0, m_ohit = 0, m_iv = 0, m_ihit = 0;
  logic [31:0] m_oaddr = 0, m_iaddr = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mread(input logic [15:0] a);
    case (a)
      16'h0300, 16'h2300: return m_obb;
      16'h0308, 16'h2308: return m_obt;
      16'h0310, 16'h2310: return m_ibt;
      16'h0010:           return m_ibb;
      default:            return 32'h0;
    endcase
  endfunction

  task automatic mwrite(input logic [15:0] a, input logic [31:0] d);
    case (a)
      16'h0300, 16'h2300: m_obb = d & 32'hFFFFF000;
      16'h0308, 16'h2308: m_obt = d & 32'hFFFFF01F;
      16'h0310, 16'h2310: m_ibt = d & 32'hFFFFF01F;
      16'h0010:           m_ibb = d & 32'hFFFFF000;
      default: ;
    endcase
  endtask

  // R4 size rule, R1/R2 substitution, R10 pass-through
  task automatic mlook(input logic [31:0] b, input logic [31:0] t, input logic [31:0] a,
                       output logic h, output logic [31:0] o);
    int n;
    longint unsigned span;
    logic [31:0] m;
    n = int'(t[4:0]);
    if (n == 0) begin
      h = 0; o = a;
    end else begin
      if (n < 11) n = 11;
      if (n > 30) n = 30;
      span = 64'd1 << (n + 1);
      m = 32'(span - 1);
      h = ((a & ~m) == (b & ~m));
      o = h ? ((t & ~m) | (a & m)) : a;
    end
  endtask

  task automatic step();
    logic h; logic [31:0] o; logic rdy;
    #1;
    check(rd === mread(ra), (mread(ra) == 0) ? "R6/R7 read zero" : "R5 register read", rd, mread(ra));
    rdy = !m_ov || ob_or;
    check(ob_ir === rdy, "R9 ob in_ready", 32'(ob_ir), 32'(rdy));
    if (rdy) begin
      m_ov = ob_iv;
      if (ob_iv) begin mlook(m_obb, m_obt, ob_ia, h, o); m_ohit = h; m_oaddr = o; end
    end
    rdy = !m_iv || ib_or;
    check(ib_ir === rdy, "R9 ib in_ready", 32'(ib_ir), 32'(rdy));
    if (rdy) begin
      m_iv = ib_iv;
      if (ib_iv) begin mlook(m_ibb, m_ibt, ib_ia, h, o); m_ihit = h; m_iaddr = o; end
    end
    if (wr) mwrite(ra, wd);  // R8: applies after this edge's lookups
    @(negedge clk);
    check(ob_ov === m_ov, "R8 ob out_valid", 32'(ob_ov), 32'(m_ov));
    if (m_ov) begin
      check(ob_hit === m_ohit, (m_obt[4:0] == 0) ? "R3 ob hit" : "R1 ob hit", 32'(ob_hit), 32'(m_ohit));
      check(ob_oa === m_oaddr, m_ohit ? "R1 ob addr" : "R10 ob addr", ob_oa, m_oaddr);
    end
    check(ib_ov === m_iv, "R8 ib out_valid", 32'(ib_ov), 32'(m_iv));
    if (m_iv) begin
      check(ib_hit === m_ihit, (m_ibt[4:0] == 0) ? "R3 ib hit" : "R2 ib hit", 32'(ib_hit), 32'(m_ihit));
      check(ib_oa === m_iaddr, m_ihit ? "R2 ib addr" : "R10 ib addr", ib_oa, m_iaddr);
    end
  endtask

  function automatic logic [15:0] pick_ofs(input int k);
    case (k)
      0: return 16'h0300; 1: return 16'h2300; 2: return 16'h0308; 3: return 16'h2308;
      4: return 16'h0310; 5: return 16'h2310; 6: return 16'h0010; 7: return 16'h0304;
      8: return 16'h1300; default: return 16'h0014;
    endcase
  endfunction

  function automatic logic [31:0] near(input logic [31:0] b);
    if ($urandom_range(0, 2) == 0) return $urandom;
    return (b & 32'hFFE00000) | ($urandom & 32'h003FFFFF);
  endfunction

  task automatic wreg(input logic [15:0] a, input logic [31:0] d);
    wr = 1; ra = a; wd = d; step(); wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7: reset state on every mapped offset
    for (int k = 0; k < 10; k++) begin ra = pick_ofs(k); step(); end
    // R3: lanes disabled after reset, lookups with random addresses
    for (int i = 0; i < 40; i++) begin
      ob_iv = 1; ib_iv = 1; ob_ia = $urandom; ib_ia = $urandom; step();
    end
    ob_iv = 0; ib_iv = 0;
    // R5: program through both aliases, with stray bits in the data
    wreg(16'h0300, 32'h8000_0ABC);
    wreg(16'h2308, 32'h4000_0F13);   // size code 19 -> 1 MiB
    wreg(16'h0010, 32'h0010_0FFF);
    wreg(16'h2310, 32'h0123_40EF);   // size code 15 -> 64 KiB
    // R6: unmapped writes ignored, then read back
    wreg(16'h0304, 32'hFFFF_FFFF);
    wreg(16'h1310, 32'hFFFF_FFFF);
    for (int k = 0; k < 10; k++) begin ra = pick_ofs(k); step(); end
    // R1/R2/R10: directed hits and misses
    ob_iv = 1; ob_ia = 32'h8004_5678; ib_iv = 1; ib_ia = 32'h0010_9ABC; step();
    ob_ia = 32'h8010_0000; ib_ia = 32'h0011_0000; step();
    // R8: write and lookup in the same cycle, old size used
    wr = 1; ra = 16'h0308; wd = 32'h4000_0000; ob_ia = 32'h8000_1000; step(); wr = 0;
    ob_ia = 32'h8000_1000; step();
    wreg(16'h0308, 32'h4000_0001);   // R4: code 1 treated as 11
    ob_iv = 1; ob_ia = 32'h8000_0FFF; step(); ob_ia = 32'h8000_1FFF; step();
    // R1-R10 mixed: random traffic, writes, sizes and back-pressure
    for (int i = 0; i < 600; i++) begin
      ob_iv = $urandom_range(0, 3) != 0;
      ib_iv = $urandom_range(0, 3) != 0;
      ob_or = $urandom_range(0, 2) != 0;
      ib_or = $urandom_range(0, 2) != 0;
      ob_ia = near(m_obb);
      ib_ia = near(m_ibb);
      ra = pick_ofs($urandom_range(0, 9));
      wr = $urandom_range(0, 9) == 0;
      wd = $urandom;
      if ($urandom_range(0, 1) == 0) wd[4:0] = 5'($urandom_range(10, 31));
      step();
    end
    wr = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule